// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block performs the single state-update step that a processor takes when it accepts a trap. The trap is either an exception or an interrupt. The surrounding core supplies the trap cause and trap value, and the block computes where execution continues. It decides whether the trap goes to supervisor mode, to machine mode, or into the debug environment. It also produces the values the control/status register file must write for that mode. The CSR file owns the registers. This block receives their current contents as inputs, and on the edge after a request it returns registered results. Each result comes with a write strobe that names the target mode.

Routing follows a fixed priority:
1. A trap taken while the hart is already in debug mode only redirects the program counter.
2. A software breakpoint can be diverted into debug mode by a per-privilege enable.
3. Any other trap goes to supervisor mode when the privilege level and the delegation masks allow it, and to machine mode otherwise.

Machine-mode interrupts can be vectored, which adds an offset to the handler base. Supervisor and machine entry also tell the memory system to drop any outstanding load reservation.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `pc_load`, `wr_s`, `wr_m`, `wr_dbg` and `resv_clr` all 0, `priv_next` = 3 (machine), and every data output zero.
- R2: A request with `trap_valid` high at edge N makes `pc_load` high for exactly the cycle after edge N. In that cycle at most one of `wr_s`, `wr_m`, `wr_dbg` is high. With no request, all strobes are low.
- R3: When `dbg_mode` is 1, a request jumps to `DBG_ENTRY` if the cause equals 3 (breakpoint) and to `DBG_EXC` for any other cause. No write strobe and no `resv_clr` is raised, and `priv_next` equals `cur_priv`.
- R4: Outside debug mode, cause 3 with the enable bit for the current privilege set (`ebrk_m` for 3, `ebrk_s` for 1, `ebrk_u` for 0) gives the following outputs:
  - `wr_dbg`, `pc_next` = `DBG_ENTRY` and `priv_next` = 3;
  - `dbg_why` = 1, `rec_epc` = `cur_pc` and `upd_pp` = `cur_priv`;
  - no `resv_clr`.
- R5: Cause bit XLEN-1 marks an interrupt. The delegation mask is `mideleg` for interrupts and `medeleg` for exceptions. The mask is indexed by the cause with bit XLEN-1 cleared (the code).
- R6: A trap is delegated to supervisor mode only when all of the following hold: `cur_priv` is 0 (user) or 1 (supervisor), the code is below XLEN, and the indexed mask bit is 1. Machine privilege never delegates.
- R7: Supervisor entry gives the following outputs:
  - `wr_s`, with `pc_next` = `stvec`;
  - `rec_cause` = the full cause, `rec_epc` = `cur_pc` and `rec_tval` = `trap_tval`;
  - `upd_pie` = `st_sie` and `upd_pp` = `cur_priv`;
  - `priv_next` = 1.

  The strobe also means the supervisor enable is to be cleared.
- R8: Machine entry sets `pc_next` to `mtvec` with bit 0 cleared. If `mtvec` bit 0 is 1 and the trap is an interrupt, 4 × code is added.
- R9: Machine entry gives the following outputs:
  - `wr_m`, with `rec_cause`, `rec_epc` and `rec_tval` as in R7;
  - `upd_pie` = `st_mie` and `upd_pp` = `cur_priv`;
  - `priv_next` = 3.

  The strobe also means the machine enable is to be cleared.
- R10: `resv_clr` is high in exactly the cycles in which `wr_s` or `wr_m` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_valid | input | 1 | One-cycle trap request |
| trap_cause | input | XLEN | Cause; MSB set for interrupts |
| trap_tval | input | XLEN | Trap value |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| dbg_mode | input | 1 | Hart already in debug mode |
| ebrk_m | input | 1 | Breakpoint-to-debug enable in M |
| ebrk_s | input | 1 | Breakpoint-to-debug enable in S |
| ebrk_u | input | 1 | Breakpoint-to-debug enable in U |
| st_sie | input | 1 | Current supervisor interrupt enable |
| st_mie | input | 1 | Current machine interrupt enable |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| stvec | input | XLEN | Supervisor handler base |
| mtvec | input | XLEN | Machine handler base; bit 0 selects vectoring |
| pc_load | output | 1 | Redirect strobe |
| pc_next | output | XLEN | Redirect target |
| priv_next | output | 2 | Privilege after the trap |
| wr_s | output | 1 | Supervisor trap records valid |
| wr_m | output | 1 | Machine trap records valid |
| wr_dbg | output | 1 | Debug entry records valid |
| rec_cause | output | XLEN | Cause to record |
| rec_epc | output | XLEN | Exception PC (or debug PC) to record |
| rec_tval | output | XLEN | Trap value to record |
| upd_pie | output | 1 | New previous-enable value |
| upd_pp | output | 2 | Previous privilege to record |
| dbg_why | output | 3 | Debug entry reason (1 = software breakpoint) |
| resv_clr | output | 1 | Drop load reservation |

## Verification
Every result is registered once. A request driven before edge N is therefore visible from just after edge N. It stays valid until the next request, while the strobes fall again after edge N+1. The bench drives each request on a falling edge and checks the redirect, the strobes and the records on the following falling edge. It then checks one falling edge later that the strobes have dropped. The sweep covers every privilege level, exception and interrupt codes 0 to 31 plus one code above XLEN, two delegation patterns, both vectoring settings, several breakpoint-enable combinations, and debug mode. Expected targets come from arithmetic in the bench.

// File: rtl/trap_pkg.sv
// Shared encodings for the trap entry controller.
// Assumes privilege levels encoded U=0, S=1, M=3.
package trap_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [2:0] DBG_WHY_SWBP = 3'd1;

    typedef enum logic [2:0] {
        RT_DBG_BRK   = 3'd0,   // already in debug, breakpoint
        RT_DBG_EXC   = 3'd1,   // already in debug, other trap
        RT_DBG_ENTER = 3'd2,   // breakpoint diverted into debug
        RT_SUP       = 3'd3,   // delegated to supervisor
        RT_MACH      = 3'd4    // handled in machine mode
    } route_e;
endpackage

// File: rtl/trap_router.sv
// Decides where a trap is taken.
// Priority: already-in-debug, breakpoint diverted to debug, supervisor
// delegation, machine. Assumes XLEN is a power of two.
module trap_router
    import trap_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int BRK_CODE = 3
) (
    input  logic [XLEN-1:0] cause,
    input  logic [1:0]      priv,
    input  logic            dbg_mode,
    input  logic            ebrk_m,
    input  logic            ebrk_s,
    input  logic            ebrk_u,
    input  logic [XLEN-1:0] medeleg,
    input  logic [XLEN-1:0] mideleg,
    output route_e          route,
    output logic            is_intr,
    output logic [XLEN-1:0] code
);
    localparam int CW = $clog2(XLEN);

    logic            is_brk;
    logic            brk_en;
    logic            code_small;
    logic [XLEN-1:0] dmask;
    logic            to_sup;

    // Classify the cause and look up the delegation bit.
    always_comb begin
        is_intr    = cause[XLEN-1];
        code       = {1'b0, cause[XLEN-2:0]};
        is_brk     = (cause == XLEN'(BRK_CODE));
        dmask      = is_intr ? mideleg : medeleg;
        code_small = ((code >> CW) == '0);
        to_sup     = (priv == PRIV_U || priv == PRIV_S) && code_small
                     && dmask[code[CW-1:0]];
        case (priv)
            PRIV_M:  brk_en = ebrk_m;
            PRIV_S:  brk_en = ebrk_s;
            PRIV_U:  brk_en = ebrk_u;
            default: brk_en = 1'b0;
        endcase
    end

    // Apply the routing priority.
    always_comb begin
        if (dbg_mode)             route = is_brk ? RT_DBG_BRK : RT_DBG_EXC;
        else if (is_brk && brk_en) route = RT_DBG_ENTER;
        else if (to_sup)          route = RT_SUP;
        else                      route = RT_MACH;
    end
endmodule

// File: rtl/trap_target.sv
// Computes the redirect address for a routed trap.
// Machine base has bit 0 cleared; bit 0 set plus an interrupt adds 4 x code.
module trap_target
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC   = 'h808
) (
    input  route_e          route,
    input  logic            is_intr,
    input  logic [XLEN-1:0] code,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] m_base;
    logic [XLEN-1:0] m_off;

    // Machine handler base plus optional vector offset.
    always_comb begin
        m_base = {mtvec[XLEN-1:1], 1'b0};
        m_off  = (mtvec[0] && is_intr) ? (code << 2) : '0;
    end

    // Select the target by route.
    always_comb begin
        case (route)
            RT_DBG_BRK, RT_DBG_ENTER: target = DBG_ENTRY;
            RT_DBG_EXC:               target = DBG_EXC;
            RT_SUP:                   target = stvec;
            default:                  target = m_base + m_off;
        endcase
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
// Trap entry step: on a one-cycle request, registers the redirect, the new
// privilege and the records for the selected mode, with one strobe per mode.
// Assumes the CSR file applies the strobes and supplies current state.
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC   = 'h808
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap_valid,
    input  logic [XLEN-1:0] trap_cause,
    input  logic [XLEN-1:0] trap_tval,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [1:0]      cur_priv,
    input  logic            dbg_mode,
    input  logic            ebrk_m,
    input  logic            ebrk_s,
    input  logic            ebrk_u,
    input  logic            st_sie,
    input  logic            st_mie,
    input  logic [XLEN-1:0] medeleg,
    input  logic [XLEN-1:0] mideleg,
    input  logic [XLEN-1:0] stvec,
    input  logic [XLEN-1:0] mtvec,
    output logic            pc_load,
    output logic [XLEN-1:0] pc_next,
    output logic [1:0]      priv_next,
    output logic            wr_s,
    output logic            wr_m,
    output logic            wr_dbg,
    output logic [XLEN-1:0] rec_cause,
    output logic [XLEN-1:0] rec_epc,
    output logic [XLEN-1:0] rec_tval,
    output logic            upd_pie,
    output logic [1:0]      upd_pp,
    output logic [2:0]      dbg_why,
    output logic            resv_clr
);
    route_e          route;
    logic            is_intr;
    logic [XLEN-1:0] code;
    logic [XLEN-1:0] target;

    trap_router #(.XLEN(XLEN)) u_router (
        .cause    (trap_cause),
        .priv     (cur_priv),
        .dbg_mode (dbg_mode),
        .ebrk_m   (ebrk_m),
        .ebrk_s   (ebrk_s),
        .ebrk_u   (ebrk_u),
        .medeleg  (medeleg),
        .mideleg  (mideleg),
        .route    (route),
        .is_intr  (is_intr),
        .code     (code)
    );

    trap_target #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY), .DBG_EXC(DBG_EXC)) u_target (
        .route   (route),
        .is_intr (is_intr),
        .code    (code),
        .stvec   (stvec),
        .mtvec   (mtvec),
        .target  (target)
    );

    // Strobes: pulse for one cycle per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_load  <= 1'b0;
            wr_s     <= 1'b0;
            wr_m     <= 1'b0;
            wr_dbg   <= 1'b0;
            resv_clr <= 1'b0;
        end else begin
            pc_load  <= trap_valid;
            wr_s     <= trap_valid && route == RT_SUP;
            wr_m     <= trap_valid && route == RT_MACH;
            wr_dbg   <= trap_valid && route == RT_DBG_ENTER;
            resv_clr <= trap_valid && (route == RT_SUP || route == RT_MACH);
        end
    end

    // Data: captured on a request, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_next   <= '0;
            priv_next <= PRIV_M;
            rec_cause <= '0;
            rec_epc   <= '0;
            rec_tval  <= '0;
            upd_pie   <= 1'b0;
            upd_pp    <= PRIV_U;
            dbg_why   <= '0;
        end else if (trap_valid) begin
            pc_next <= target;
            case (route)
                RT_SUP: begin
                    priv_next <= PRIV_S;
                    rec_cause <= trap_cause;
                    rec_epc   <= cur_pc;
                    rec_tval  <= trap_tval;
                    upd_pie   <= st_sie;
                    upd_pp    <= cur_priv;
                end
                RT_MACH: begin
                    priv_next <= PRIV_M;
                    rec_cause <= trap_cause;
                    rec_epc   <= cur_pc;
                    rec_tval  <= trap_tval;
                    upd_pie   <= st_mie;
                    upd_pp    <= cur_priv;
                end
                RT_DBG_ENTER: begin
                    priv_next <= PRIV_M;
                    rec_epc   <= cur_pc;
                    upd_pp    <= cur_priv;
                    dbg_why   <= DBG_WHY_SWBP;
                end
                default: priv_next <= cur_priv;
            endcase
        end
    end
endmodule

// File: rtl/trap_entry_chk.sv
// Checker for trap_entry_ctrl, bound to every instance.
// Observes ports only; all properties are off while reset is low.
module trap_entry_chk #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] DBG_ENTRY = 'h800
) (
    input logic            clk,
    input logic            rst_n,
    input logic            trap_valid,
    input logic            dbg_mode,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] stvec,
    input logic            pc_load,
    input logic [XLEN-1:0] pc_next,
    input logic [1:0]      priv_next,
    input logic            wr_s,
    input logic            wr_m,
    input logic            wr_dbg,
    input logic [1:0]      upd_pp,
    input logic [2:0]      dbg_why,
    input logic            resv_clr
);
    // R2
    pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> pc_load);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_valid |=> !pc_load && !wr_s && !wr_m && !wr_dbg && !resv_clr);
    // R2
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_s, wr_m, wr_dbg}));
    // R3
    debug_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && dbg_mode |=> !wr_s && !wr_m && !wr_dbg && !resv_clr
                                   && priv_next == $past(cur_priv));
    // R4
    dbg_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dbg |-> pc_next == DBG_ENTRY && priv_next == 2'd3 && dbg_why == 3'd1);
    // R6
    mach_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid && !dbg_mode && cur_priv == 2'd3 |=> !wr_s);
    // R7
    sup_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_s |-> pc_next == $past(stvec) && priv_next == 2'd1);
    // R9
    mach_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_m |-> priv_next == 2'd3 && upd_pp == $past(cur_priv));
    // R10
    resv_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resv_clr == (wr_s || wr_m));
endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN), .DBG_ENTRY(DBG_ENTRY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_valid (trap_valid),
    .dbg_mode   (dbg_mode),
    .cur_priv   (cur_priv),
    .stvec      (stvec),
    .pc_load    (pc_load),
    .pc_next    (pc_next),
    .priv_next  (priv_next),
    .wr_s       (wr_s),
    .wr_m       (wr_m),
    .wr_dbg     (wr_dbg),
    .upd_pp     (upd_pp),
    .dbg_why    (dbg_why),
    .resv_clr   (resv_clr)
);

// File: tb/tb_trap_entry_ctrl.sv
// Sweep bench for trap_entry_ctrl: privileges x codes x kinds x configurations.
module tb_trap_entry_ctrl;
    localparam int          XLEN  = 32;
    localparam logic [31:0] D_ENT = 32'h800;
    localparam logic [31:0] D_EXC = 32'h808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [31:0] trap_cause = '0, trap_tval = '0, cur_pc = '0;
    logic [1:0]  cur_priv = '0;
    logic        dbg_mode = 1'b0, ebrk_m = 1'b0, ebrk_s = 1'b0, ebrk_u = 1'b0;
    logic        st_sie = 1'b0, st_mie = 1'b0;
    logic [31:0] medeleg = '0, mideleg = '0, stvec = '0, mtvec = '0;
    logic        pc_load, wr_s, wr_m, wr_dbg, upd_pie, resv_clr;
    logic [31:0] pc_next, rec_cause, rec_epc, rec_tval;
    logic [1:0]  priv_next, upd_pp;
    logic [2:0]  dbg_why;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    trap_entry_ctrl #(.XLEN(XLEN), .DBG_ENTRY(D_ENT), .DBG_EXC(D_EXC)) dut (
        .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .trap_tval(trap_tval), .cur_pc(cur_pc), .cur_priv(cur_priv),
        .dbg_mode(dbg_mode), .ebrk_m(ebrk_m), .ebrk_s(ebrk_s), .ebrk_u(ebrk_u),
        .st_sie(st_sie), .st_mie(st_mie), .medeleg(medeleg), .mideleg(mideleg),
        .stvec(stvec), .mtvec(mtvec), .pc_load(pc_load), .pc_next(pc_next),
        .priv_next(priv_next), .wr_s(wr_s), .wr_m(wr_m), .wr_dbg(wr_dbg),
        .rec_cause(rec_cause), .rec_epc(rec_epc), .rec_tval(rec_tval),
        .upd_pie(upd_pie), .upd_pp(upd_pp), .dbg_why(dbg_why), .resv_clr(resv_clr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pc_load == 0 && wr_s == 0 && wr_m == 0 && wr_dbg == 0 && resv_clr == 0,
            "R1 strobes", {27'd0, pc_load, wr_s, wr_m, wr_dbg, resv_clr}, 32'd0);
        chk(priv_next == 2'd3, "R1 priv", {30'd0, priv_next}, 32'd3);
        chk(pc_next == 0 && rec_epc == 0 && rec_cause == 0, "R1 data", pc_next, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int it = 0; it < 2; it++) begin
                    for (int c = 0; c < 33; c++) begin
                        logic [1:0]  p;
                        logic [31:0] code, cause, e_pc, dl, e_cause;
                        logic        brk, ben, to_s, e_ws, e_wm, e_wd, e_pie;
                        logic [1:0]  e_priv;
                        p     = (pi == 2) ? 2'd3 : 2'(pi);
                        code  = (c == 32) ? 32'd40 : 32'(c);
                        cause = {it[0], code[30:0]};
                        // drive request
                        trap_cause = cause;
                        trap_tval  = 32'hBEEF_0000 ^ (code << 8) ^ 32'(v);
                        cur_pc     = 32'h1000_0000 + code * 4 + 32'(v) * 256 + 32'(p);
                        cur_priv   = p;
                        dbg_mode   = (v >= 8);
                        ebrk_m     = v[1];
                        ebrk_s     = v[1] ^ v[2];
                        ebrk_u     = v[2];
                        st_sie     = code[0];
                        st_mie     = code[1] ^ v[0];
                        medeleg    = v[2] ? 32'hA5A5_5A5A : 32'h5A5A_A5A5;
                        mideleg    = v[1] ? 32'h0F0F_F0F0 : 32'hF0F0_0F0F;
                        stvec      = 32'h0000_2000 | (32'(v) << 4);
                        mtvec      = 32'h0000_4000 | (32'(v) << 8) | 32'(v % 2);
                        trap_valid = 1'b1;
                        // model
                        brk = (cause == 32'd3);
                        ben = (p == 2'd3 && ebrk_m) || (p == 2'd1 && ebrk_s) ||
                              (p == 2'd0 && ebrk_u);
                        dl  = cause[31] ? mideleg : medeleg;
                        to_s = (p != 2'd3) && (code < 32) && dl[code[4:0]];
                        e_ws = 0; e_wm = 0; e_wd = 0;
                        e_cause = cause;
                        if (dbg_mode) begin
                            e_pc = brk ? D_ENT : D_EXC;
                            e_priv = p;
                            e_pie = 0;
                        end else if (brk && ben) begin
                            e_pc = D_ENT; e_wd = 1; e_priv = 2'd3; e_pie = 0;
                        end else if (to_s) begin
                            e_pc = stvec; e_ws = 1; e_priv = 2'd1; e_pie = st_sie;
                        end else begin
                            e_pc = {mtvec[31:1], 1'b0} +
                                   ((mtvec[0] && cause[31]) ? code * 4 : 32'd0);
                            e_wm = 1; e_priv = 2'd3; e_pie = st_mie;
                        end
                        @(negedge clk);
                        trap_valid = 1'b0;
                        // R2 pulse and single mode
                        chk(pc_load == 1'b1, "R2 pc_load", {31'd0, pc_load}, 32'd1);
                        // R3 R4 R6 R7 R8: route and target
                        chk(pc_next == e_pc,
                            dbg_mode ? "R3 target" : (e_wd ? "R4 target" :
                            (e_ws ? "R7 target" : "R8 target")), pc_next, e_pc);
                        // R5 R6: mode selection
                        chk({wr_s, wr_m, wr_dbg} == {e_ws, e_wm, e_wd}, "R5 R6 mode",
                            {29'd0, wr_s, wr_m, wr_dbg}, {29'd0, e_ws, e_wm, e_wd});
                        chk(priv_next == e_priv, "R7 R9 priv", {30'd0, priv_next},
                            {30'd0, e_priv});
                        // R10
                        chk(resv_clr == (e_ws | e_wm), "R10 resv", {31'd0, resv_clr},
                            {31'd0, e_ws | e_wm});
                        if (e_ws || e_wm) begin
                            // R7 R9 records
                            chk(rec_cause == e_cause && rec_epc == cur_pc &&
                                rec_tval == trap_tval, "R7 R9 records", rec_epc, cur_pc);
                            chk(upd_pie == e_pie && upd_pp == p, "R7 R9 status",
                                {29'd0, upd_pie, upd_pp}, {29'd0, e_pie, p});
                        end
                        if (e_wd) begin
                            // R4 debug records
                            chk(rec_epc == cur_pc && upd_pp == p && dbg_why == 3'd1,
                                "R4 records", rec_epc, cur_pc);
                        end
                        @(negedge clk);
                        // R2: strobes fall with no request
                        chk(!pc_load && !wr_s && !wr_m && !wr_dbg && !resv_clr,
                            "R2 idle", {27'd0, pc_load, wr_s, wr_m, wr_dbg, resv_clr},
                            32'd0);
                    end
                end
            end
        end
        finish_run();
    end
endmodule